// File: doc/BRIEF.md
# Gray-Coded Timestamp Source

This block is the single time reference for a trace router. It runs a binary tick counter whose width is a parameter (30 bits by default) and broadcasts the value to every trace client in Gray code. Clients in other clock domains can then sample it with at most one bit in flight. Alongside the count it sends a timestamp-valid flag and a 2-bit granularity mode. The clients use the mode to decide how often a message carries a stamp.

Software drives three control inputs: an enable level, a restart bit and the mode field. The count advances once per clock while enabled and freezes while disabled. A 0-to-1 step on the restart bit starts a one-cycle clearing phase. During that phase the valid flag is withdrawn. After it the count starts again from zero if enabling is still set.

A small state machine sequences the block. Its states are IDLE (frozen), RUN (counting) and CLEAR (restart in progress). Its transitions are:
- IDLE→RUN when enable is set.
- RUN→IDLE when enable is cleared.
- Any state→CLEAR on a restart edge.
- CLEAR→RUN or CLEAR→IDLE after one cycle, chosen by enable.

All three broadcast outputs come from registers and share a latency of two clocks from the control inputs.

Top module: `ts_gray_source`

## Requirements
- R1: While reset is asserted and right after it, ts_valid is 0, ts_gray is all zeros and ts_mode is 0.
- R2: The ts_mode value after clock edge m+1 equals the cfg_mode value sampled at edge m.
- R3: If cfg_enable is 1 at edge m and no restart edge occurs there, ts_valid is 1 after edge m+1. The count then advances by exactly one per clock for as long as that continues.
- R4: ts_gray carries the count as g = b XOR (b >> 1). While ts_valid stays 1 on consecutive cycles, exactly one bit of ts_gray changes per cycle.
- R5: While cfg_enable is 0, the count holds its value and ts_valid is 0 from two edges after enable was cleared.
- R6: A restart edge (cfg_restart 0 at edge m-1 and 1 at edge m) gives ts_valid = 0 after edge m+1. After edge m+2, ts_gray is zero and ts_valid equals cfg_enable as sampled at edge m+1.
- R7: Holding cfg_restart at 1 for several edges clears the count only once. Only a 0-to-1 step restarts.
- R8: A restart edge while disabled still zeroes the count. Counting later resumes from zero when enable is set.
- R9: At the counter width's top value (all ones), the next step wraps to zero with a single Gray bit change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Counting enable level |
| cfg_restart | input | 1 | Restart control; a rising step clears the count |
| cfg_mode | input | 2 | Granularity mode to broadcast |
| ts_valid | output | 1 | Timestamp-enable flag to clients |
| ts_gray | output | CNT_W | Count value in Gray code |
| ts_mode | output | 2 | Broadcast granularity mode |

## Verification
Every broadcast output is due two clock edges after the control value that sets it. Edge m moves the state machine, edge m+1 moves the count and the output registers. The driver task applies inputs on a falling edge and runs a requirement-level model at the following rising edge. It then queues the expected valid, Gray and mode values. The monitor takes each item off the queue only after one more rising edge and compares it on the falling edge, so every comparison lands in the cycle where the result is due. A second instance with a 4-bit counter reaches the wrap point within the run.

// File: rtl/ts_pkg.sv
`timescale 1ns/1ps
package ts_pkg;
    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_RUN   = 2'd1,
        TS_CLEAR = 2'd2
    } ts_state_e;
endpackage

// File: rtl/ts_seq_fsm.sv
`timescale 1ns/1ps
module ts_seq_fsm
    import ts_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_restart,
    input  logic [MODE_W-1:0] cfg_mode,
    output ts_state_e         state_o,
    output logic [MODE_W-1:0] mode_o
);
    ts_state_e         state_q;
    ts_state_e         state_d;
    logic              restart_prev_q;
    logic              restart_edge;
    logic [MODE_W-1:0] mode_q;

    assign restart_edge = cfg_restart & ~restart_prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE:  state_d = cfg_enable ? TS_RUN : TS_IDLE;
            TS_RUN:   state_d = cfg_enable ? TS_RUN : TS_IDLE;
            TS_CLEAR: state_d = cfg_enable ? TS_RUN : TS_IDLE;
            default:  state_d = TS_IDLE;
        endcase
        if (restart_edge) begin
            state_d = TS_CLEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= TS_IDLE;
            restart_prev_q <= 1'b0;
            mode_q         <= '0;
        end else begin
            state_q        <= state_d;
            restart_prev_q <= cfg_restart;
            mode_q         <= cfg_mode;
        end
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;

    AST_CLEAR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_CLEAR && !(cfg_restart && !restart_prev_q)) |=> (state_q != TS_CLEAR)); // R6

    AST_LEVEL_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_restart && restart_prev_q) |=> (state_q != TS_CLEAR)); // R7
endmodule

// File: rtl/ts_bin_counter.sv
`timescale 1ns/1ps
module ts_bin_counter #(
    parameter int CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt_o = cnt_q;

    AST_ZERO_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0)); // R6

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/ts_gray_reg.sv
`timescale 1ns/1ps
module ts_gray_reg #(
    parameter int CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] bin_i,
    output logic [CNT_W-1:0] gray_o
);
    logic [CNT_W-1:0] gray_d;

    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_bit
            if (i == CNT_W - 1) begin : g_top
                assign gray_d[i] = bin_i[i];
            end else begin : g_mid
                assign gray_d[i] = bin_i[i] ^ bin_i[i+1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_o <= '0;
        end else begin
            gray_o <= gray_d;
        end
    end
endmodule

// File: rtl/ts_gray_source.sv
`timescale 1ns/1ps
module ts_gray_source
    import ts_pkg::*;
#(
    parameter int CNT_W  = 30,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_restart,
    input  logic [MODE_W-1:0] cfg_mode,
    output logic              ts_valid,
    output logic [CNT_W-1:0]  ts_gray,
    output logic [MODE_W-1:0] ts_mode
);
    ts_state_e         fsm_state;
    logic [MODE_W-1:0] mode_stage;
    logic [CNT_W-1:0]  cnt_bin;
    logic              cnt_clear;
    logic              cnt_step;

    ts_seq_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_enable  (cfg_enable),
        .cfg_restart (cfg_restart),
        .cfg_mode    (cfg_mode),
        .state_o     (fsm_state),
        .mode_o      (mode_stage)
    );

    assign cnt_clear = (fsm_state == TS_CLEAR);
    assign cnt_step  = (fsm_state == TS_RUN);

    ts_bin_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .step_i  (cnt_step),
        .cnt_o   (cnt_bin)
    );

    ts_gray_reg #(.CNT_W(CNT_W)) u_gray (
        .clk    (clk),
        .rst_n  (rst_n),
        .bin_i  (cnt_bin),
        .gray_o (ts_gray)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_valid <= 1'b0;
            ts_mode  <= '0;
        end else begin
            ts_valid <= (fsm_state == TS_RUN);
            ts_mode  <= mode_stage;
        end
    end

    AST_GRAY_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && $past(ts_valid)) |-> ($countones(ts_gray ^ $past(ts_gray)) == 1)); // R4

    AST_VALID_DROP_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == TS_CLEAR) |=> !ts_valid); // R6
endmodule

// File: tb/test_ts_gray_source.sv
`timescale 1ns/1ps
module test_ts_gray_source;
    localparam int W  = 30;
    localparam int WS = 4;

    typedef struct {
        logic          valid;
        logic [W-1:0]  gray;
        logic [WS-1:0] gray_s;
        logic [1:0]    mode;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic          cfg_restart = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          ts_valid, s_valid;
    logic [W-1:0]  ts_gray;
    logic [WS-1:0] s_gray;
    logic [1:0]    ts_mode, s_mode;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // model state: 0 idle, 1 run, 2 clear
    int           m_st = 0;
    logic [W-1:0] m_bin = '0;
    logic         m_prev = 1'b0;

    always #2.5 clk = ~clk;

    ts_gray_source i_ts_gray_source (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_restart(cfg_restart),
        .cfg_mode(cfg_mode), .ts_valid(ts_valid), .ts_gray(ts_gray), .ts_mode(ts_mode)
    );

    ts_gray_source #(.CNT_W(WS)) i_small (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_restart(cfg_restart),
        .cfg_mode(cfg_mode), .ts_valid(s_valid), .ts_gray(s_gray), .ts_mode(s_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic rs, input logic [1:0] md, input string req);
        exp_t it;
        logic pulse;
        logic [WS-1:0] b4;
        @(negedge clk);
        cfg_enable  = en;
        cfg_restart = rs;
        cfg_mode    = md;
        @(posedge clk);
        pulse  = rs && !m_prev;
        m_prev = rs;
        if (m_st == 2) m_bin = '0;
        else if (m_st == 1) m_bin = m_bin + 1'b1;
        m_st = pulse ? 2 : (en ? 1 : 0);
        b4 = m_bin[WS-1:0];
        it.valid  = (m_st == 1);
        it.gray   = m_bin ^ (m_bin >> 1);
        it.gray_s = b4 ^ (b4 >> 1);
        it.mode   = md;
        it.req    = req;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        while (q.size() > 1) begin
            exp_t e;
            e = q.pop_front();
            chk(ts_valid === e.valid, e.req, "valid", 64'(ts_valid), 64'(e.valid));
            chk(ts_gray === e.gray, e.req, "gray", 64'(ts_gray), 64'(e.gray));
            chk(ts_mode === e.mode, "R2", "mode", 64'(ts_mode), 64'(e.mode));
            chk(s_gray === e.gray_s, "R9", "small gray", 64'(s_gray), 64'(e.gray_s));
        end
    end

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ts_valid === 1'b0, "R1", "valid in reset", 64'(ts_valid), 64'(0));
        chk(ts_gray === '0, "R1", "gray in reset", 64'(ts_gray), 64'(0));
        chk(ts_mode === 2'd0, "R1", "mode in reset", 64'(ts_mode), 64'(0));
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(ts_valid === 1'b0 && ts_gray === '0, "R1", "after reset", 64'(ts_gray), 64'(0));
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 2'd0, "R5");
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 2'd2, "R3");
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 2'(i), "R4");
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 2'd1, "R5");
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 2'd3, "R3");
        drive(1'b1, 1'b1, 2'd3, "R6");
        drive(1'b1, 1'b1, 2'd3, "R6");
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 2'd3, "R7");
        for (int i = 0; i < 24; i++) drive(1'b1, 1'b0, 2'd0, "R9");
        drive(1'b0, 1'b1, 2'd1, "R8");
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 2'd1, "R8");
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 2'd1, "R8");
        drive(1'b1, 1'b1, 2'd2, "R6");
        drive(1'b1, 1'b0, 2'd2, "R6");
        drive(1'b1, 1'b1, 2'd2, "R6");
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 2'd2, "R6");
        drive(1'b0, 1'b0, 2'd0, "R5");
        drive(1'b0, 1'b0, 2'd0, "R5");
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule